// File: doc/BRIEF.md
# Memory-Type-Aware Cache Controller

A small direct-mapped data cache that picks its caching policy per access. Each processor request carries a two-bit memory type. The type decides whether a miss allocates a line, whether a write stays in the array or goes out to memory, and whether a matching line is dropped. Four policies share one data array and one tag store: bypass, write-through, write-back and write-protected.

The processor holds a request until the controller returns a one-cycle acknowledge. A cache hit is acknowledged on the cycle after the request is seen. Any access that needs the memory bus keeps the processor waiting until the bus work is finished. On the memory side, the controller issues one word transaction at a time and holds it until the memory raises ready. Line fills and write-backs are sequences of such word transactions. A separate invalidate request drops one line and writes it back first if it is dirty. Only one miss or bus operation is in flight at a time.

Top module: `mtype_cache`

## Requirements
- R1: After reset every line is invalid. The acknowledge outputs and the memory request are low, so the first cacheable read of any address fetches a whole line.
- R2: Memory type 0 (bypass) performs exactly one single-word memory transaction with the request's byte enables. It leaves every line's data, valid and dirty state unchanged.
- R3: A read of type 1, 2 or 3 that hits returns the cached word, is acknowledged one cycle after it is presented, and causes no bus traffic. A read miss fetches the 4 words of the line in ascending offset order (offset is address bits [1:0]) and then returns the requested word.
- R4: A type 2 (write-back) write that misses fetches the line first. A type 2 write that hits or allocates updates only the array and marks the line dirty, with no memory write at that time.
- R5: When a fill needs a slot that holds a valid dirty line, the 4 words of that line are written to memory before the first fill read is issued.
- R6: A type 1 (write-through) write always makes exactly one memory write. On a hit it also updates the cached word in place. On a miss it does not fill or allocate.
- R7: A type 3 (write-protected) write makes exactly one memory write, never updates the array, and leaves any matching line invalid. If that line was dirty, it is written back first.
- R8: An invalidate whose address matches a valid line drops that line and writes it back first if it is dirty. An invalidate that matches no line has no effect.
- R9: Byte-enable bit i governs data bits 8i+7..8i. Only enabled bytes change in cached writes and in single-word memory writes.
- R10: The processor acknowledge pulses for one cycle and only after all memory transactions of the access are done. A memory request holds its address, direction and data stable until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address: tag, index, offset[1:0] |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_be_i | input | DATA_W/8 | Byte enables |
| cpu_mtype_i | input | 2 | 0 bypass, 1 write-through, 2 write-back, 3 write-protected |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with the acknowledge |
| inv_req_i | input | 1 | Invalidate request, held until acknowledged |
| inv_addr_i | input | ADDR_W | Address whose line is invalidated |
| inv_ack_o | output | 1 | One-cycle invalidate completion pulse |
| mem_req_o | output | 1 | Memory word transaction request |
| mem_we_o | output | 1 | 1 = memory write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_be_o | output | DATA_W/8 | Memory write byte enables |
| mem_ready_i | input | 1 | Memory completes the transaction this cycle |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ready |

## Verification
Corrupted internal state shows up at the ports quickly and in a recognisable way. A lost dirty bit leaves stale words in memory, and a bypass read of that address exposes them at once. A lost or stale valid bit changes the number of bus reads on the very next access to that line, and it turns a one-cycle hit into a multi-cycle fill or the reverse. The bench predicts the word-read and word-write counts, the returned data and the hit latency of every access with a reference model. It also checks the fill order, and that each eviction finishes before the first fill read. After a final flush it compares the whole memory image.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {MT_UC = 2'd0, MT_WT = 2'd1, MT_WB = 2'd2, MT_WP = 2'd3} mtype_e;
  typedef enum logic [2:0] {ST_IDLE, ST_EVICT, ST_FILL, ST_BUS, ST_RESP} state_e;
endpackage

// File: rtl/mtc_data_ram.sv
module mtc_data_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BE_W; b++) begin
      if (we && be[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mtc_tag_store.sv
module mtc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 5,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             dirty_set,
  input  logic             dirty_clr,
  input  logic             valid_clr,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (alloc_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else begin
      if (valid_clr) begin
        valid_q[idx] <= 1'b0;
        dirty_q[idx] <= 1'b0;
      end else if (dirty_set) begin
        dirty_q[idx] <= 1'b1;
      end else if (dirty_clr) begin
        dirty_q[idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[idx] <= alloc_tag;
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

  // R4
  dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    line_dirty |-> line_valid);
endmodule

// File: rtl/mtype_cache.sv
module mtype_cache
  import mtc_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  localparam int BE_W   = DATA_W / 8,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int RAM_AW = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic [BE_W-1:0]   cpu_be_i,
  input  logic [1:0]        cpu_mtype_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              inv_req_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              inv_ack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [BE_W-1:0]   mem_be_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  state_e            state_q, state_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic              op_we_q, op_inv_q, ld_op, ld_inv;
  mtype_e            op_mt_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [BE_W-1:0]   op_be_q;
  logic              ack_q, ack_d, inv_ack_q, inv_ack_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic              idle_free, take_inv, take_cpu, hit, mem_xfer;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx, op_idx;
  logic [TAG_W-1:0]  cur_tag, op_tag, look_tag;
  logic              look_valid, look_dirty;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [BE_W-1:0]   ram_be;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic              ts_alloc, ts_dset, ts_dclr, ts_vclr;
  mtype_e            cpu_mt;

  assign cpu_mt    = mtype_e'(cpu_mtype_i);
  assign idle_free = (state_q == ST_IDLE) && !ack_q && !inv_ack_q;
  assign take_inv  = idle_free && inv_req_i;
  assign take_cpu  = idle_free && !inv_req_i && cpu_req_i;
  assign cur_addr  = (state_q == ST_IDLE) ? (inv_req_i ? inv_addr_i : cpu_addr_i) : op_addr_q;
  assign cur_idx   = cur_addr[OFF_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign op_idx    = op_addr_q[OFF_W +: IDX_W];
  assign op_tag    = op_addr_q[ADDR_W-1 -: TAG_W];
  assign hit       = look_valid && (look_tag == cur_tag);
  assign mem_xfer  = mem_req_o && mem_ready_i;
  assign ram_raddr = (state_q == ST_EVICT) ? {op_idx, cnt_q} : cur_addr[RAM_AW-1:0];

  mtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst), .idx(cur_idx), .alloc_en(ts_alloc), .alloc_tag(op_tag),
    .dirty_set(ts_dset), .dirty_clr(ts_dclr), .valid_clr(ts_vclr),
    .line_valid(look_valid), .line_dirty(look_dirty), .line_tag(look_tag));

  mtc_data_ram #(.DEPTH(LINES * LINE_WORDS), .DATA_W(DATA_W)) data_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .be(ram_be), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata));

  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;  rdata_d = rdata_q;
    ack_d = 1'b0;  inv_ack_d = 1'b0;  ld_op = 1'b0;  ld_inv = 1'b0;
    ram_we = 1'b0;  ram_waddr = cur_addr[RAM_AW-1:0];
    ram_be = cpu_be_i;  ram_wdata = cpu_wdata_i;
    ts_alloc = 1'b0;  ts_dset = 1'b0;  ts_dclr = 1'b0;  ts_vclr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (take_inv) begin
          ld_inv = 1'b1;
          if (hit && look_dirty) state_d = ST_EVICT;
          else begin
            ts_vclr   = hit;
            inv_ack_d = 1'b1;
          end
        end else if (take_cpu) begin
          ld_op = 1'b1;
          if (cpu_mt == MT_UC) state_d = ST_BUS;
          else if (hit && !cpu_we_i) begin
            ack_d   = 1'b1;
            rdata_d = ram_rdata;
          end else if (cpu_we_i && cpu_mt == MT_WT) begin
            ram_we  = hit;
            state_d = ST_BUS;
          end else if (cpu_we_i && cpu_mt == MT_WP) begin
            if (hit && look_dirty) state_d = ST_EVICT;
            else begin
              ts_vclr = hit;
              state_d = ST_BUS;
            end
          end else if (hit) begin
            ram_we  = 1'b1;
            ts_dset = 1'b1;
            ack_d   = 1'b1;
          end else begin
            state_d = (look_valid && look_dirty) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: if (mem_xfer) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_OFF) begin
          ts_dclr = 1'b1;
          if (op_inv_q) begin
            ts_vclr   = 1'b1;
            inv_ack_d = 1'b1;
            state_d   = ST_IDLE;
          end else if (op_we_q && op_mt_q == MT_WP) begin
            ts_vclr = 1'b1;
            state_d = ST_BUS;
          end else state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        ram_we    = mem_xfer;
        ram_waddr = {op_idx, cnt_q};
        ram_be    = '1;
        ram_wdata = mem_rdata_i;
        if (mem_xfer) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_OFF) begin
            ts_alloc = 1'b1;
            state_d  = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        rdata_d   = ram_rdata;
        ack_d     = 1'b1;
        ram_we    = op_we_q;
        ram_be    = op_be_q;
        ram_wdata = op_wdata_q;
        ts_dset   = op_we_q;
        state_d   = ST_IDLE;
      end
      ST_BUS: if (mem_xfer) begin
        rdata_d = mem_rdata_i;
        ack_d   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;  cnt_q <= '0;  ack_q <= 1'b0;  inv_ack_q <= 1'b0;
      rdata_q <= '0;  op_inv_q <= 1'b0;  op_we_q <= 1'b0;  op_mt_q <= MT_UC;
      op_addr_q <= '0;  op_wdata_q <= '0;  op_be_q <= '0;
    end else begin
      state_q <= state_d;  cnt_q <= cnt_d;  ack_q <= ack_d;
      inv_ack_q <= inv_ack_d;  rdata_q <= rdata_d;
      if (ld_op) begin
        op_inv_q <= 1'b0;  op_we_q <= cpu_we_i;  op_mt_q <= cpu_mt;
        op_addr_q <= cpu_addr_i;  op_wdata_q <= cpu_wdata_i;  op_be_q <= cpu_be_i;
      end else if (ld_inv) begin
        op_inv_q <= 1'b1;  op_we_q <= 1'b0;  op_addr_q <= inv_addr_i;
      end
    end
  end

  assign cpu_ack_o   = ack_q;
  assign cpu_rdata_o = rdata_q;
  assign inv_ack_o   = inv_ack_q;
  assign mem_req_o   = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_BUS);
  assign mem_we_o    = (state_q == ST_EVICT) || ((state_q == ST_BUS) && op_we_q);
  assign mem_addr_o  = (state_q == ST_EVICT) ? {look_tag, op_idx, cnt_q} :
                       (state_q == ST_FILL)  ? {op_tag, op_idx, cnt_q} : op_addr_q;
  assign mem_wdata_o = (state_q == ST_EVICT) ? ram_rdata : op_wdata_q;
  assign mem_be_o    = (state_q == ST_BUS) ? op_be_q : '1;

  // R10
  ack_after_bus_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ack_o |-> !mem_req_o);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R5
  fill_clean_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |-> !look_dirty);
  // R2
  bypass_no_state_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUS && op_mt_q == MT_UC)
      |-> !(ts_alloc || ts_vclr || ts_dset || ts_dclr || ram_we));
  // R6
  wt_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |-> !(op_we_q && op_mt_q == MT_WT));
  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ack_o |=> !cpu_ack_o);
endmodule

// File: tb/mtype_cache_tb.sv
module mtype_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, DW = 32, BEW = 4, MEMW = 1024;

  logic clk = 1'b0, rst;
  logic cpu_req, cpu_we, cpu_ack, inv_req, inv_ack;
  logic [AW-1:0] cpu_addr, inv_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic [BEW-1:0] cpu_be, mem_be;
  logic [1:0] cpu_mt;
  logic mem_req, mem_we, mem_ready;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mtype_cache dut_i (
    .clk(clk), .rst(rst), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be), .cpu_mtype_i(cpu_mt), .cpu_ack_o(cpu_ack),
    .cpu_rdata_o(cpu_rdata), .inv_req_i(inv_req), .inv_addr_i(inv_addr), .inv_ack_o(inv_ack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata));

  logic [DW-1:0] bus_mem [MEMW];
  logic [DW-1:0] ref_mem [MEMW];
  logic [DW-1:0] r_data [32];
  bit r_valid [8], r_dirty [8];
  logic [4:0] r_tag [8];
  int n_chk = 0, n_err = 0;
  int bus_rd, bus_wr, seq, first_rd_seq, last_wr_seq, e_rd, e_wr;
  logic [AW-1:0] rd_log [4];

  assign mem_rdata = bus_mem[mem_addr];

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (!rst && mem_req && mem_ready) begin
      seq++;
      if (mem_we) begin
        for (int b = 0; b < BEW; b++)
          if (mem_be[b]) bus_mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        bus_wr++;
        last_wr_seq = seq;
      end else begin
        if (bus_rd < 4) rd_log[bus_rd] = mem_addr;
        if (first_rd_seq == 0) first_rd_seq = seq;
        bus_rd++;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) o[b*8 +: 8] = n[b*8 +: 8];
    return o;
  endfunction

  function automatic logic [AW-1:0] mk(int t, int i, int o);
    return {t[4:0], i[2:0], o[1:0]};
  endfunction

  task automatic ref_evict(int i);
    for (int k = 0; k < 4; k++) ref_mem[mk(r_tag[i], i, k)] = r_data[i*4 + k];
    e_wr += 4;
    r_dirty[i] = 0;
  endtask

  task automatic ref_fill(int i, logic [4:0] t);
    if (r_valid[i] && r_dirty[i]) ref_evict(i);
    for (int k = 0; k < 4; k++) r_data[i*4 + k] = ref_mem[mk(t, i, k)];
    e_rd += 4;
    r_valid[i] = 1; r_dirty[i] = 0; r_tag[i] = t;
  endtask

  task automatic ref_cpu(bit we, logic [AW-1:0] a, logic [31:0] wd, logic [3:0] be,
                         logic [1:0] mt, output logic [31:0] erd);
    int i = int'(a[4:2]);
    int w = int'(a[4:0]);
    logic [4:0] t = a[9:5];
    bit h = r_valid[i] && (r_tag[i] == t);
    erd = 'x;
    if (mt == 2'd0) begin
      if (we) begin ref_mem[a] = merge(ref_mem[a], wd, be); e_wr++; end
      else begin erd = ref_mem[a]; e_rd++; end
    end else if (!we) begin
      if (!h) ref_fill(i, t);
      erd = r_data[w];
    end else if (mt == 2'd1) begin
      if (h) r_data[w] = merge(r_data[w], wd, be);
      ref_mem[a] = merge(ref_mem[a], wd, be); e_wr++;
    end else if (mt == 2'd2) begin
      if (!h) ref_fill(i, t);
      r_data[w] = merge(r_data[w], wd, be);
      r_dirty[i] = 1;
    end else begin
      if (h) begin
        if (r_dirty[i]) ref_evict(i);
        r_valid[i] = 0; r_dirty[i] = 0;
      end
      ref_mem[a] = merge(ref_mem[a], wd, be); e_wr++;
    end
  endtask

  task automatic clear_mon();
    bus_rd = 0; bus_wr = 0; seq = 0; first_rd_seq = 0; last_wr_seq = 0;
    e_rd = 0; e_wr = 0;
  endtask

  task automatic run_cpu(string tag, bit we, logic [AW-1:0] a, logic [31:0] wd,
                         logic [3:0] be, logic [1:0] mt, output logic [31:0] got);
    logic [31:0] exp;
    int cyc = 0;
    @(negedge clk);
    clear_mon();
    ref_cpu(we, a, wd, be, mt, exp);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be; cpu_mt = mt;
    do begin @(negedge clk); cyc++; end while (!cpu_ack && cyc < 2000);
    cpu_req = 0;
    got = cpu_rdata;
    if (cyc >= 2000) chk({tag, " R10 ack timeout"}, 0, 1);
    if (!we) chk({tag, " rdata"}, cpu_rdata, exp);
    chk({tag, " bus reads"}, bus_rd, e_rd);
    chk({tag, " bus writes"}, bus_wr, e_wr);
    if (e_rd + e_wr == 0) chk({tag, " R3 hit latency"}, cyc, 1);
  endtask

  task automatic run_inv(string tag, logic [AW-1:0] a);
    int cyc = 0;
    int i = int'(a[4:2]);
    @(negedge clk);
    clear_mon();
    if (r_valid[i] && r_tag[i] == a[9:5]) begin
      if (r_dirty[i]) ref_evict(i);
      r_valid[i] = 0; r_dirty[i] = 0;
    end
    inv_req = 1; inv_addr = a;
    do begin @(negedge clk); cyc++; end while (!inv_ack && cyc < 2000);
    inv_req = 0;
    if (cyc >= 2000) chk({tag, " R8 inv timeout"}, 0, 1);
    chk({tag, " inv bus writes"}, bus_wr, e_wr);
    chk({tag, " inv bus reads"}, bus_rd, 0);
  endtask

  task automatic chk_fill(string tag, int t, int i);
    for (int k = 0; k < 4; k++) chk({tag, " R3 fill order"}, rd_log[k], mk(t, i, k));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] g;
    void'($urandom(32'd1234));
    for (int k = 0; k < MEMW; k++) begin
      bus_mem[k] = (k * 32'h01010101) ^ 32'hA5A5_0000;
      ref_mem[k] = bus_mem[k];
    end
    for (int k = 0; k < 8; k++) begin r_valid[k] = 0; r_dirty[k] = 0; r_tag[k] = '0; end
    rst = 1; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0; cpu_mt = '0;
    inv_req = 0; inv_addr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset ack", cpu_ack, 0);
    chk("R1 reset inv ack", inv_ack, 0);
    chk("R1 reset mem req", mem_req, 0);

    // R1 R3: first read misses and fills in order, then a hit
    run_cpu("R1 first read", 0, mk(1, 2, 3), 0, 4'hF, 2'd2, g);
    chk_fill("R1", 1, 2);
    run_cpu("R3 read hit", 0, mk(1, 2, 0), 0, 4'hF, 2'd2, g);
    // R4 R9: write-back hit with partial bytes, read back
    run_cpu("R4 wb write hit", 1, mk(1, 2, 1), 32'h1122_3344, 4'b0101, 2'd2, g);
    run_cpu("R9 read merged", 0, mk(1, 2, 1), 0, 4'hF, 2'd2, g);
    chk("R9 byte merge", g, merge(bus_mem[mk(1, 2, 1)], 32'h1122_3344, 4'b0101));
    // R2: bypass read sees stale memory, cache keeps dirty data
    run_cpu("R2 bypass read", 0, mk(1, 2, 1), 0, 4'hF, 2'd0, g);
    chk("R2 stale memory", g, bus_mem[mk(1, 2, 1)]);
    run_cpu("R2 cache unchanged", 0, mk(1, 2, 1), 0, 4'hF, 2'd2, g);
    run_cpu("R2 bypass write", 1, mk(1, 2, 2), 32'hDEAD_BEEF, 4'b1000, 2'd0, g);
    run_cpu("R2 bypass write hidden", 0, mk(1, 2, 2), 0, 4'hF, 2'd2, g);
    // R5: conflicting read evicts dirty line before fill
    run_cpu("R5 evict then fill", 0, mk(3, 2, 0), 0, 4'hF, 2'd2, g);
    chk("R5 writes before reads", (last_wr_seq < first_rd_seq) ? 1 : 0, 1);
    chk_fill("R5", 3, 2);
    // R6: write-through miss, fill, hit
    run_cpu("R6 wt write miss", 1, mk(0, 5, 1), 32'hCAFE_0001, 4'hF, 2'd1, g);
    run_cpu("R6 wt read miss", 0, mk(0, 5, 1), 0, 4'hF, 2'd1, g);
    run_cpu("R6 wt write hit", 1, mk(0, 5, 2), 32'h0BAD_F00D, 4'b0011, 2'd1, g);
    run_cpu("R6 wt updated in place", 0, mk(0, 5, 2), 0, 4'hF, 2'd2, g);
    // R7: write-protected
    run_cpu("R7 wp read miss", 0, mk(2, 6, 0), 0, 4'hF, 2'd3, g);
    run_cpu("R7 wp write hit", 1, mk(2, 6, 0), 32'h7777_7777, 4'hF, 2'd3, g);
    run_cpu("R7 wp line dropped", 0, mk(2, 6, 0), 0, 4'hF, 2'd3, g);
    run_cpu("R7 make dirty", 1, mk(2, 6, 3), 32'h5555_AAAA, 4'hF, 2'd2, g);
    run_cpu("R7 wp write dirty", 1, mk(2, 6, 1), 32'h1234_5678, 4'b1100, 2'd3, g);
    chk("R7 writeback plus single", bus_wr, 5);
    // R4: write-back write miss allocates, no memory write
    run_cpu("R4 wb write miss", 1, mk(4, 7, 2), 32'hFACE_FACE, 4'hF, 2'd2, g);
    run_cpu("R4 memory untouched", 0, mk(4, 7, 2), 0, 4'hF, 2'd0, g);
    // R8: invalidate
    run_inv("R8 dirty inv", mk(4, 7, 0));
    chk("R8 dirty writes", bus_wr, 4);
    run_cpu("R8 after inv", 0, mk(4, 7, 2), 0, 4'hF, 2'd0, g);
    chk("R8 written back", g, 32'hFACE_FACE);
    run_inv("R8 miss inv", mk(7, 5, 0));
    run_cpu("R8 other line kept", 0, mk(0, 5, 2), 0, 4'hF, 2'd1, g);
    run_inv("R8 clean inv", mk(0, 5, 0));
    run_cpu("R8 clean refetch", 0, mk(0, 5, 2), 0, 4'hF, 2'd1, g);

    // R10: random mix of types, conflicts and invalidates
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a = mk($urandom % 4, $urandom % 8, $urandom % 4);
      if ($urandom % 10 == 0) run_inv("R8 random inv", a);
      else begin
        logic [3:0] be = 4'($urandom % 15 + 1);
        run_cpu("R10 random", 1'($urandom % 2), a, $urandom, be, 2'($urandom % 4), g);
      end
    end

    // R5 R8: flush and compare the memory image
    for (int i = 0; i < 8; i++) if (r_valid[i]) run_inv("R8 flush", mk(r_tag[i], i, 0));
    @(negedge clk);
    begin
      int bad = 0;
      for (int k = 0; k < MEMW; k++) if (bus_mem[k] !== ref_mem[k]) bad++;
      chk("R5 memory image mismatches", bad, 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule